// File: doc/BRIEF.md
# Memory Section Access Arbiter

This block grants one memory section to one of three masters: the processor, the read side of a DMA engine and the write side of that engine. One copy sits in front of each section (register space, nonvolatile page buffer, working RAM and so on), so two masters can work in two different sections in the same cycle. Each master drives a request, a burst flag and an end-of-burst mark. The arbiter answers with a registered one-hot grant, a busy flag, and a beat strobe that marks the final cycle of every access.

Priority has four levels. An access already under way is never cut short. A master that is partway through a burst comes next, and when both DMA sides stream into the same section their beats are interleaved. After that, a new burst beats a new single access. Within each level the processor is served before DMA. A parameter picks the kind of section, and the kind sets how many cycles a write, a single read and a streamed burst read take.

Top module: `mem_section_arbiter`

## Requirements
- R1: After reset, grant is 000, busy and beat are low, and the DMA tie pointer favours the read side.
- R2: Grant bit 0 is the processor, bit 1 the DMA read side and bit 2 the DMA write side. At most one bit is set. A grant appears at the clock edge after the requests are seen while the section is free. busy is high exactly while a grant is held.
- R3: A granted access keeps its grant unchanged until its beat cycle has passed. No request can preempt it.
- R4: A master that finishes a burst beat with burst high, end mark low and its request still high wins the next beat over every new request, including the processor's.
- R5: While either DMA side has a burst in progress and the other side asks for a burst, the two sides are both in the second level. The tie pointer then makes them take turns. Each DMA grant points the pointer at the other side.
- R6: Among new requests, a request with burst high wins over a single access.
- R7: Within a level the processor wins. Between two DMA candidates the tie pointer decides.
- R8: A write (DMA write side, or processor with cpu_we high) takes WR_LAT cycles. A single read (DMA read side, or processor with cpu_we low) takes RD_LAT cycles. beat is high in the last cycle of each access.
- R9: A read beat that directly follows the same master's unfinished burst beat takes STREAM_LAT cycles instead of RD_LAT.
- R10: With no request at a free edge, no grant is given, busy falls and the tie pointer keeps its value.
- R11: Default timings are: register section 1/1/1, working RAM write 1 / read 2 / stream 1, nonvolatile buffer write 1 / read 3 / stream 2 (written as write/read/stream).
- R12: A burst in progress ends when a beat completes with the end mark high, or whenever that master's request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 3 | Request per master (bit 0 processor, 1 DMA read, 2 DMA write) |
| burst | input | 3 | Burst flag per master |
| last | input | 3 | End-of-burst mark per master, sampled at the end of a beat |
| cpu_we | input | 1 | Processor access is a write |
| grant | output | 3 | Registered one-hot grant |
| busy | output | 1 | An access is in progress |
| beat | output | 1 | Final cycle of the current access |

## Verification
The hardest state to reach from the ports is two DMA bursts interleaving in one section while the processor also asks for access. To get there, one DMA side must already hold an unfinished burst when the other side raises a burst request. The end marks must also stay low across several beats whose length depends on the section kind. The bench drives random phases with one bias per phase (both DMA sides forced into long bursts, singles only, rare end marks). It runs three section kinds side by side and compares every cycle against an independent cycle model. Directed transfers add exact cycle counts for single and streamed accesses.

// File: rtl/msa_pkg.sv
package msa_pkg;

  typedef enum logic [1:0] {
    SEC_IO     = 2'd0,
    SEC_SRAM   = 2'd1,
    SEC_EEPROM = 2'd2
  } sec_kind_e;

  localparam int NUM_M = 3;
  localparam int M_CPU = 0;
  localparam int M_DRD = 1;
  localparam int M_DWR = 2;

  // Single-read access time per section kind
  function automatic int base_read_cycles(sec_kind_e k);
    case (k)
      SEC_SRAM:   return 2;
      SEC_EEPROM: return 3;
      default:    return 1;
    endcase
  endfunction

  // Write access time per section kind
  function automatic int base_write_cycles(sec_kind_e k);
    case (k)
      SEC_SRAM:   return 1;
      SEC_EEPROM: return 1;
      default:    return 1;
    endcase
  endfunction

  // Streamed burst-read beat interval per section kind
  function automatic int base_stream_cycles(sec_kind_e k);
    case (k)
      SEC_EEPROM: return 2;
      default:    return 1;
    endcase
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Cycles one beat occupies the section
  function automatic int beat_cycles(logic is_rd, logic strm, int rd, int wr, int gap);
    if (!is_rd) return wr;
    if (strm)   return gap;
    return rd;
  endfunction

  // Processor first, DMA pair split by tie pointer (alt=1 favours write side)
  function automatic logic [NUM_M-1:0] pick_master(logic [NUM_M-1:0] c, logic alt);
    logic [NUM_M-1:0] r;
    r = '0;
    if (c[M_CPU])                  r[M_CPU] = 1'b1;
    else if (c[M_DRD] && c[M_DWR]) r[alt ? M_DWR : M_DRD] = 1'b1;
    else if (c[M_DRD])             r[M_DRD] = 1'b1;
    else if (c[M_DWR])             r[M_DWR] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/msa_tier_select.sv
module msa_tier_select
  import msa_pkg::*;
(
  input  logic [NUM_M-1:0] req,
  input  logic [NUM_M-1:0] burst,
  input  logic [NUM_M-1:0] inb,
  input  logic             alt,
  output logic [NUM_M-1:0] win_oh,
  output logic             win_any
);

  logic [NUM_M-1:0] t_hold;
  logic [NUM_M-1:0] t_burst;
  logic [NUM_M-1:0] sel;

  // Level two: unfinished bursts; a DMA side joins when its partner streams
  always_comb begin
    t_hold        = inb;
    t_hold[M_DRD] = inb[M_DRD] | (req[M_DRD] & burst[M_DRD] & inb[M_DWR]);
    t_hold[M_DWR] = inb[M_DWR] | (req[M_DWR] & burst[M_DWR] & inb[M_DRD]);
  end

  assign t_burst = req & burst;

  always_comb begin
    if (|t_hold)       sel = t_hold;
    else if (|t_burst) sel = t_burst;
    else               sel = req;
  end

  assign win_oh  = pick_master(sel, alt);
  assign win_any = |sel;

endmodule

// File: rtl/msa_beat_timer.sv
module msa_beat_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             free,
  output logic             ending,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;

  assign free   = (cnt_q <= CNT_W'(1));
  assign ending = (cnt_q == CNT_W'(1));
  assign busy   = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (free) cnt_q <= load_en ? load_val : '0;
    else           cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/msa_burst_track.sv
module msa_burst_track
  import msa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ending,
  input  logic [NUM_M-1:0] owner,
  input  logic [NUM_M-1:0] req,
  input  logic [NUM_M-1:0] burst,
  input  logic [NUM_M-1:0] last,
  input  logic             free,
  input  logic             win_any,
  input  logic             drd_won,
  input  logic             dwr_won,
  output logic [NUM_M-1:0] inb_eff,
  output logic             alt_q
);

  logic [NUM_M-1:0] inb_q;
  logic [NUM_M-1:0] inb_mid;

  // Owner's flag is re-evaluated as its beat retires
  for (genvar m = 0; m < NUM_M; m++) begin : g_flag
    assign inb_mid[m] = (ending && owner[m]) ? (burst[m] & ~last[m]) : inb_q[m];
  end

  assign inb_eff = inb_mid & req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inb_q <= '0;
      alt_q <= 1'b0;
    end else begin
      inb_q <= inb_eff;
      if (free && win_any && (drd_won || dwr_won))
        alt_q <= drd_won;
    end
  end

endmodule

// File: rtl/mem_section_arbiter.sv
module mem_section_arbiter
  import msa_pkg::*;
#(
  parameter sec_kind_e   SEC_KIND   = SEC_SRAM,
  parameter int unsigned RD_LAT     = base_read_cycles(SEC_KIND),
  parameter int unsigned WR_LAT     = base_write_cycles(SEC_KIND),
  parameter int unsigned STREAM_LAT = base_stream_cycles(SEC_KIND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] req,
  input  logic [NUM_M-1:0] burst,
  input  logic [NUM_M-1:0] last,
  input  logic             cpu_we,
  output logic [NUM_M-1:0] grant,
  output logic             busy,
  output logic             beat
);

  localparam int MAX_LAT = max3(int'(RD_LAT), int'(WR_LAT), int'(STREAM_LAT));
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic             free;
  logic             ending;
  logic [NUM_M-1:0] inb_eff;
  logic             alt_q;
  logic [NUM_M-1:0] win_oh;
  logic             win_any;
  logic [NUM_M-1:0] grant_q;
  logic             win_read;
  logic             win_stream;
  logic [CNT_W-1:0] load_val;

  msa_tier_select u_sel (
    .req     (req),
    .burst   (burst),
    .inb     (inb_eff),
    .alt     (alt_q),
    .win_oh  (win_oh),
    .win_any (win_any)
  );

  msa_burst_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .ending  (ending),
    .owner   (grant_q),
    .req     (req),
    .burst   (burst),
    .last    (last),
    .free    (free),
    .win_any (win_any),
    .drd_won (win_oh[M_DRD]),
    .dwr_won (win_oh[M_DWR]),
    .inb_eff (inb_eff),
    .alt_q   (alt_q)
  );

  assign win_read   = win_oh[M_DRD] | (win_oh[M_CPU] & ~cpu_we);
  assign win_stream = ending && (win_oh == grant_q) && |(win_oh & inb_eff);
  assign load_val   = CNT_W'(beat_cycles(win_read, win_stream,
                                         int'(RD_LAT), int'(WR_LAT), int'(STREAM_LAT)));

  msa_beat_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (win_any),
    .load_val (load_val),
    .free     (free),
    .ending   (ending),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    grant_q <= '0;
    else if (free) grant_q <= win_any ? win_oh : '0;
  end

  assign grant = grant_q;
  assign beat  = ending;

endmodule

// File: rtl/msa_checker.sv
module msa_checker
  import msa_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_M-1:0] req,
  input logic [NUM_M-1:0] grant,
  input logic             busy,
  input logic             beat,
  input logic             free,
  input logic             win_any,
  input logic [NUM_M-1:0] win_oh,
  input logic             alt_q
);

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_busy_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (grant != '0));

  p_grant_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (free && win_any) |=> grant == $past(win_oh));

  p_no_preempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat) |=> $stable(grant));

  p_alt_to_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (free && win_any && win_oh[M_DRD]) |=> alt_q);

  p_alt_to_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (free && win_any && win_oh[M_DWR]) |=> !alt_q);

  p_idle_nogrant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (free && req == '0) |=> (grant == '0 && !busy));

  p_alt_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !win_any) |=> $stable(alt_q));

endmodule

bind mem_section_arbiter msa_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .grant   (grant),
  .busy    (busy),
  .beat    (beat),
  .free    (free),
  .win_any (win_any),
  .win_oh  (win_oh),
  .alt_q   (alt_q)
);

// File: tb/msa_ref.sv
module msa_ref #(
  parameter int RD  = 1,
  parameter int WR  = 1,
  parameter int GAP = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req,
  input  logic [2:0] burst,
  input  logic [2:0] last,
  input  logic       we,
  output logic [2:0] e_grant,
  output logic       e_busy,
  output logic       e_beat
);

  int       rem;
  int       own;
  bit [2:0] held;
  bit       ptr;

  // Level 2: unfinished bursts (DMA partner joins); 3: new bursts; 4: any
  function automatic int choose();
    for (int lvl = 2; lvl <= 4; lvl++) begin
      bit [2:0] c;
      if (lvl == 2) begin
        c[0] = held[0];
        c[1] = held[1] || (req[1] && burst[1] && held[2]);
        c[2] = held[2] || (req[2] && burst[2] && held[1]);
      end else if (lvl == 3) begin
        c = req & burst;
      end else begin
        c = req;
      end
      if (c != 3'b000) begin
        if (c[0]) return 0;
        if (c[1] && c[2]) return ptr ? 2 : 1;
        return c[1] ? 1 : 2;
      end
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; own = -1; held = 3'b000; ptr = 1'b0;
    end else if (rem > 1) begin
      rem  = rem - 1;
      held = held & req;
    end else begin
      int w;
      bit rd;
      bit strm;
      bit was_end;
      was_end = (rem == 1);
      if (was_end && own >= 0) held[own] = burst[own] && !last[own];
      held = held & req;
      w = choose();
      if (w < 0) begin
        own = -1; rem = 0;
      end else begin
        rd   = (w == 1) || (w == 0 && !we);
        strm = was_end && (own == w) && held[w];
        rem  = !rd ? WR : (strm ? GAP : RD);
        own  = w;
        if (w == 1) ptr = 1'b1;
        if (w == 2) ptr = 1'b0;
      end
    end
    e_grant = (own >= 0) ? 3'(1 << own) : 3'b000;
    e_busy  = (rem != 0);
    e_beat  = (rem == 1);
  end

endmodule

// File: tb/mem_section_arbiter_test.sv
`timescale 1ns/1ps
module mem_section_arbiter_test;
  import msa_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] req = 3'b000, burst = 3'b000, last = 3'b000;
  logic       cpu_we = 1'b0;

  logic [2:0] g_e, g_s, g_i, x_e, x_s, x_i;
  logic       b_e, b_s, b_i, t_e, t_s, t_i;
  logic       xb_e, xb_s, xb_i, xt_e, xt_s, xt_i;

  // Index 0 nonvolatile buffer, 1 working RAM, 2 register section (R11)
  int rd_tab[3] = '{3, 2, 1};
  int wr_tab[3] = '{1, 1, 1};
  int gp_tab[3] = '{2, 1, 1};

  int    vectors = 0;
  int    misses  = 0;
  int    cycles  = 0;
  bit    cmp_en  = 1'b0;
  string tag     = "R1";

  mem_section_arbiter #(.SEC_KIND(SEC_EEPROM)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst), .last(last),
    .cpu_we(cpu_we), .grant(g_e), .busy(b_e), .beat(t_e));
  mem_section_arbiter #(.SEC_KIND(SEC_SRAM)) uut_s (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst), .last(last),
    .cpu_we(cpu_we), .grant(g_s), .busy(b_s), .beat(t_s));
  mem_section_arbiter #(.SEC_KIND(SEC_IO)) uut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst), .last(last),
    .cpu_we(cpu_we), .grant(g_i), .busy(b_i), .beat(t_i));

  msa_ref #(.RD(3), .WR(1), .GAP(2)) m_e (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst), .last(last), .we(cpu_we),
    .e_grant(x_e), .e_busy(xb_e), .e_beat(xt_e));
  msa_ref #(.RD(2), .WR(1), .GAP(1)) m_s (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst), .last(last), .we(cpu_we),
    .e_grant(x_s), .e_busy(xb_s), .e_beat(xt_s));
  msa_ref #(.RD(1), .WR(1), .GAP(1)) m_i (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst), .last(last), .we(cpu_we),
    .e_grant(x_i), .e_busy(xb_i), .e_beat(xt_i));

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 150000", cycles);
      finish_run();
    end
  end

  task automatic cmp(string nm, logic [2:0] ag, logic [2:0] eg, logic ab, logic eb,
                     logic at, logic et);
    vectors++;
    if (ag !== eg || ab !== eb || at !== et) begin
      misses++;
      $display("FAIL %s %s: grant/busy/beat actual %b/%b/%b expected %b/%b/%b",
               tag, nm, ag, ab, at, eg, eb, et);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      cmp("nvbuf", g_e, x_e, b_e, xb_e, t_e, xt_e);
      cmp("ram",   g_s, x_s, b_s, xb_s, t_s, xt_s);
      cmp("regs",  g_i, x_i, b_i, xb_i, t_i, xt_i);
    end
  end

  task automatic check_val(string t, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  function automatic logic busy_of(int k);
    case (k)
      0:       return b_e;
      1:       return b_s;
      default: return b_i;
    endcase
  endfunction

  function automatic logic beat_of(int k);
    case (k)
      0:       return t_e;
      1:       return t_s;
      default: return t_i;
    endcase
  endfunction

  function automatic logic [2:0] grant_of(int k);
    case (k)
      0:       return g_e;
      1:       return g_s;
      default: return g_i;
    endcase
  endfunction

  task automatic go_idle();
    @(negedge clk);
    req = 3'b000; burst = 3'b000; last = 3'b000;
    repeat (6) @(negedge clk);
  endtask

  // One request pattern from idle; grant checked on all three sections
  task automatic first_grant(string t, logic [2:0] r, logic [2:0] b, logic [2:0] exp);
    go_idle();
    req = r; burst = b;
    @(negedge clk);
    for (int k = 0; k < 3; k++) check_val(t, int'(grant_of(k)), int'(exp));
    req = 3'b000; burst = 3'b000;
  endtask

  // Transfer of n beats by master m; counts busy cycles on section k
  task automatic transfer(string t, int k, int m, bit brst, int n, bit we, int exp);
    int beats = 0;
    int cyc   = 0;
    int guard = 0;
    go_idle();
    cpu_we   = we;
    req[m]   = 1'b1;
    burst[m] = brst;
    last[m]  = 1'b0;
    while (beats < n && guard < 200) begin
      @(negedge clk);
      guard++;
      if (busy_of(k)) cyc++;
      if (beat_of(k)) begin
        beats++;
        if (beats == n) begin
          req[m] = 1'b0; last[m] = 1'b1;
        end
      end
    end
    check_val(t, cyc, exp);
  endtask

  task automatic rnd_phase(string t, int n, int preq, int pb, int pl, logic [2:0] mask);
    tag = t;
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        req[i]   = mask[i] && ($urandom_range(99) < preq);
        burst[i] = ($urandom_range(99) < pb);
        last[i]  = ($urandom_range(99) < pl);
      end
      cpu_we = 1'($urandom_range(1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state on all sections
    for (int k = 0; k < 3; k++) begin
      check_val("R1 grant", int'(grant_of(k)), 0);
      check_val("R1 busy", int'(busy_of(k)), 0);
      check_val("R1 beat", int'(beat_of(k)), 0);
    end
    rst_n  = 1'b1;
    cmp_en = 1'b1;

    tag = "R1 R7 directed";
    first_grant("R1 R7 pointer starts at read side", 3'b110, 3'b000, 3'b010);
    first_grant("R10 R5 pointer kept across idle", 3'b110, 3'b000, 3'b100);
    first_grant("R7 processor first", 3'b111, 3'b000, 3'b001);
    first_grant("R6 burst beats single", 3'b101, 3'b100, 3'b100);
    first_grant("R6 R7 processor burst first", 3'b111, 3'b111, 3'b001);

    tag = "R8 R9 R11 directed";
    for (int k = 0; k < 3; k++) begin
      transfer("R8 R11 single read", k, M_CPU, 1'b0, 1, 1'b0, rd_tab[k]);
      transfer("R8 R11 single write", k, M_DWR, 1'b0, 1, 1'b1, wr_tab[k]);
      transfer("R9 R11 streamed read", k, M_DRD, 1'b1, 4, 1'b0, rd_tab[k] + 3 * gp_tab[k]);
      transfer("R8 burst write", k, M_CPU, 1'b1, 3, 1'b1, 3 * wr_tab[k]);
    end
    go_idle();

    rnd_phase("R2 R3 R7 singles", 3000, 40, 0, 50, 3'b111);
    rnd_phase("R4 R6 R12 bursts", 4000, 60, 50, 20, 3'b111);
    rnd_phase("R5 dma interleave", 3000, 95, 95, 5, 3'b110);
    rnd_phase("R5 R4 interleave with processor", 3000, 90, 90, 8, 3'b111);
    rnd_phase("R10 sparse", 2000, 5, 50, 50, 3'b111);
    rnd_phase("R12 request drops", 3000, 70, 80, 10, 3'b111);
    go_idle();
    finish_run();
  end

endmodule